// File: doc/BRIEF.md
# Two-Wire Slave Register Access Port

This block is a two-wire (I2C) bus slave with a fixed 7-bit device address. Through it, an external bus master reads and writes a bank of 8-bit control registers that sits beside the block. The block oversamples SCL and SDA with the system clock and finds START and STOP conditions. It compares the address byte with its own address, acknowledges, and then steps a register pointer through the bank. The register bank itself is outside the block and is reached through a plain address / write-data / write-strobe / read-data port.

A write transfer carries a sub-address byte that loads the pointer, followed by any number of data bytes. Each data byte is written at the pointer, and the pointer then advances. A read transfer sends bytes starting at the pointer, whatever value it holds. The pointer may have been left there by an earlier transfer, or set just before a repeated START. Each byte sent advances the pointer. The block drives SDA only as an open-drain pull-down enable. It never stretches the clock.

Top module: `regbus_i2c_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START and a rising SDA while SCL is high is a STOP; after a STOP the slave drives nothing (sdaOe = 0) and waits for the next START.
- R2: A first byte after START of address 7'b1000011 (sent MSB first) followed by a read/write bit (1 = read, 0 = write) is acknowledged by pulling SDA low during the ninth SCL pulse.
- R3: Any other address is not acknowledged, and SDA stays released and no register is written until the next START or STOP, even if more bytes follow.
- R4: In a write transfer, the byte after the address byte is acknowledged and loads the register pointer.
- R5: Each further byte of a write transfer is acknowledged and written to the register at the pointer with a single-cycle regWe pulse, after which the pointer advances by one (wrapping at the top of the address space).
- R6: A read transfer that follows the address byte directly returns the register at the pointer value left by the previous transfer.
- R7: In a read, a master ACK makes the slave send the register at the next address; a master NACK releases SDA and ends the read, and the pointer has advanced once per byte sent.
- R8: A repeated START after a sub-address write starts a new address byte without changing the pointer, so a read that follows returns data from the sub-address just written.
- R9: Read data is sent MSB first, and the slave changes its SDA drive only while SCL is low.
- R10: After reset SDA is released, the pointer is 0 and regWe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Bus clock from the master |
| sdaIn | input | 1 | Resolved level of the SDA wire |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain enable) |
| regAddr | output | ADDR_W | Register pointer, address for read and write |
| regWdata | output | 8 | Byte to be written |
| regWe | output | 1 | One-cycle write strobe |
| regRdata | input | 8 | Register content at regAddr (combinational read) |

## Verification
All 127 foreign device addresses are sent to the block, and each must go unacknowledged without a write. This separates a correct address compare from one that ignores or mis-positions a bit. A full 256-byte multibyte write, using an arithmetic pattern, is followed by a 256-byte sequential read from a repeated START. Together they exercise every pointer value, the wrap, MSB-first shifting and the ACK/NACK handshake. Short transfers then tell apart the pointer handling of three cases: a byte write, a random read across a repeated START, and a current-address read that relies on a pointer left by a write ending in STOP.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_SUB, ST_SUB_ACK,
    ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
  } busState_e;

  // strobes from control to datapath, at most a few active per cycle
  typedef struct packed {
    logic shiftIn;   // take the sampled SDA bit, count it
    logic bitInc;    // count a transmitted bit
    logic bitClr;    // restart the bit counter
    logic loadTx;    // load read data and start driving it
    logic shiftTx;   // advance to the next transmit bit
    logic latchPtr;  // received byte becomes the pointer
    logic wrByte;    // received byte goes to the register bank
    logic incPtr;    // a byte was sent, advance the pointer
    logic ackOn;     // pull SDA low for acknowledge
    logic relOe;     // stop driving SDA
  } dpCmd_t;
endpackage

// File: rtl/regbus_i2c_ctrl.sv
module regbus_i2c_ctrl
  import regbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000011,
  parameter int         SYNC_W   = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      scl,
  input  logic      sda,
  input  logic [3:0] bitCnt,
  input  logic [7:0] rxByte,
  output dpCmd_t    cmd,
  output logic      sdaSync,
  output busState_e state,
  output logic      stopEv
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] FULL_CNT = 4'(BYTE_W);

  logic [SYNC_W:0] sclQ, sdaQ;
  logic sclCur, sclPrev, sdaCur, sdaPrev;
  logic sclRise, sclFall, startEv;
  logic rwQ, ackHalf;
  logic nextRw, nextHalf;
  busState_e nextState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclQ <= '1;
      sdaQ <= '1;
    end else begin
      sclQ <= {sclQ[SYNC_W-1:0], scl};
      sdaQ <= {sdaQ[SYNC_W-1:0], sda};
    end
  end

  assign sclCur  = sclQ[SYNC_W-1];
  assign sclPrev = sclQ[SYNC_W];
  assign sdaCur  = sdaQ[SYNC_W-1];
  assign sdaPrev = sdaQ[SYNC_W];
  assign sdaSync = sdaCur;

  assign sclRise = sclCur & ~sclPrev;
  assign sclFall = ~sclCur & sclPrev;
  assign startEv = sclCur & sclPrev & sdaPrev & ~sdaCur;
  assign stopEv  = sclCur & sclPrev & ~sdaPrev & sdaCur;

  always_comb begin
    cmd       = '0;
    nextState = state;
    nextHalf  = ackHalf;
    nextRw    = rwQ;
    if (startEv) begin
      nextState  = ST_DEV;
      nextHalf   = 1'b0;
      cmd.bitClr = 1'b1;
      cmd.relOe  = 1'b1;
    end else if (stopEv) begin
      nextState = ST_IDLE;
      nextHalf  = 1'b0;
      cmd.relOe = 1'b1;
    end else begin
      unique case (state)
        ST_DEV: if (sclRise) begin
          cmd.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            if (rxByte[7:1] == DEV_ADDR) begin
              nextState = ST_DEV_ACK;
              nextRw    = rxByte[0];
            end else begin
              nextState = ST_SKIP;
            end
          end
        end
        ST_SUB: if (sclRise) begin
          cmd.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            cmd.latchPtr = 1'b1;
            nextState    = ST_SUB_ACK;
          end
        end
        ST_WR: if (sclRise) begin
          cmd.shiftIn = 1'b1;
          if (bitCnt == LAST_BIT) begin
            cmd.wrByte = 1'b1;
            nextState  = ST_WR_ACK;
          end
        end
        ST_DEV_ACK, ST_SUB_ACK, ST_WR_ACK: if (sclFall) begin
          if (!ackHalf) begin
            cmd.ackOn = 1'b1;
            nextHalf  = 1'b1;
          end else begin
            nextHalf = 1'b0;
            if (state == ST_DEV_ACK && rwQ) begin
              cmd.loadTx = 1'b1;
              nextState  = ST_RD;
            end else begin
              cmd.relOe  = 1'b1;
              cmd.bitClr = 1'b1;
              nextState  = (state == ST_DEV_ACK) ? ST_SUB : ST_WR;
            end
          end
        end
        ST_RD: begin
          if (sclRise) cmd.bitInc = 1'b1;
          if (sclFall) begin
            if (bitCnt == FULL_CNT) begin
              cmd.relOe  = 1'b1;
              cmd.incPtr = 1'b1;
              nextState  = ST_RD_ACK;
            end else begin
              cmd.shiftTx = 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise && sdaCur) nextState = ST_SKIP;
          else if (sclFall) begin
            cmd.loadTx = 1'b1;
            nextState  = ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      rwQ     <= 1'b0;
      ackHalf <= 1'b0;
    end else begin
      state   <= nextState;
      rwQ     <= nextRw;
      ackHalf <= nextHalf;
    end
  end
endmodule

// File: rtl/regbus_i2c_dp.sv
module regbus_i2c_dp
  import regbus_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              sdaBit,
  input  logic [BYTE_W-1:0] regRdata,
  output logic [BYTE_W-1:0] rxByte,
  output logic [3:0]        bitCnt,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWdata,
  output logic              regWe,
  output logic              sdaOe
);
  logic [BYTE_W-1:0] shReg;
  logic ackQ, txEn;

  assign rxByte = {shReg[BYTE_W-2:0], sdaBit};
  assign sdaOe  = ackQ | (txEn & ~shReg[BYTE_W-1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      bitCnt   <= '0;
      regAddr  <= '0;
      regWdata <= '0;
      regWe    <= 1'b0;
      ackQ     <= 1'b0;
      txEn     <= 1'b0;
    end else begin
      regWe <= cmd.wrByte;

      if (cmd.shiftIn)      shReg <= rxByte;
      else if (cmd.loadTx)  shReg <= regRdata;
      else if (cmd.shiftTx) shReg <= {shReg[BYTE_W-2:0], 1'b0};

      if (cmd.bitClr || cmd.loadTx)      bitCnt <= '0;
      else if (cmd.shiftIn || cmd.bitInc) bitCnt <= bitCnt + 4'd1;

      if (cmd.latchPtr)             regAddr <= rxByte[ADDR_W-1:0];
      else if (cmd.incPtr || regWe) regAddr <= regAddr + 1'b1;

      if (cmd.wrByte) regWdata <= rxByte;

      if (cmd.relOe) begin
        ackQ <= 1'b0;
        txEn <= 1'b0;
      end else if (cmd.ackOn) begin
        ackQ <= 1'b1;
      end else if (cmd.loadTx) begin
        ackQ <= 1'b0;
        txEn <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/regbus_i2c_slave.sv
module regbus_i2c_slave
  import regbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000011,
  parameter int         ADDR_W   = 8,
  parameter int         SYNC_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWdata,
  output logic              regWe,
  input  logic [7:0]        regRdata
);
  dpCmd_t    cmd;
  busState_e busState;
  logic      stopEv, sdaSync;
  logic [3:0] bitCnt;
  logic [7:0] rxByte;

  regbus_i2c_ctrl #(.DEV_ADDR(DEV_ADDR), .SYNC_W(SYNC_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sda(sdaIn),
    .bitCnt(bitCnt), .rxByte(rxByte), .cmd(cmd),
    .sdaSync(sdaSync), .state(busState), .stopEv(stopEv)
  );

  regbus_i2c_dp #(.ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sdaBit(sdaSync),
    .regRdata(regRdata), .rxByte(rxByte), .bitCnt(bitCnt),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .sdaOe(sdaOe)
  );
endmodule

// File: rtl/regbus_i2c_checks.sv
module regbus_i2c_checks
  import regbus_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              scl,
  input logic              sdaOe,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              stopEv,
  input busState_e         state
);
  // R9: drive changes only while the bus clock is low
  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !scl);

  // R5: write strobe lasts one cycle
  p_we_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R5: pointer steps by one after each write
  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> regAddr == $past(regAddr) + 1'b1);

  // R1: released after a STOP
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaOe);

  // R3: nothing happens for a foreign address
  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SKIP |-> !regWe && !sdaOe);
endmodule

bind regbus_i2c_slave regbus_i2c_checks #(.ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rstN(rstN), .scl(scl), .sdaOe(sdaOe), .regWe(regWe),
  .regAddr(regAddr), .stopEv(stopEv), .state(busState)
);

// File: tb/test_regbus_i2c_slave.sv
`timescale 1ns/1ps
module test_regbus_i2c_slave;
  localparam int Q = 6;
  localparam logic [6:0] DEV = 7'b1000011;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic mLow = 1'b0;
  logic sdaBus;
  logic sdaOe, regWe;
  logic [7:0] regAddr, regWdata, regRdata;
  logic [7:0] mem [256];
  int nChecks = 0;
  int nFail = 0;
  int weCount = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sdaBus = !(mLow || sdaOe);

  regbus_i2c_slave i_regbus_i2c_slave (
    .clk(clk), .rstN(rstN), .scl(scl), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .regAddr(regAddr), .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata)
  );

  assign regRdata = mem[regAddr];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'h00;
    end else if (regWe) begin
      mem[regAddr] <= regWdata;
      weCount <= weCount + 1;
    end
  end

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mLow = 1'b0; qw();
    scl = 1'b1;  qw();
    mLow = 1'b1; qw();
    scl = 1'b0;  qw();
  endtask

  task automatic busStop();
    qw(); mLow = 1'b1;
    qw(); scl = 1'b1;
    qw(); mLow = 1'b0;
    qw();
  endtask

  task automatic sendByte(input logic [7:0] b, output bit nack);
    for (int i = 7; i >= 0; i--) begin
      qw(); mLow = ~b[i];
      qw(); scl = 1'b1;
      qw(); qw(); scl = 1'b0;
    end
    qw(); mLow = 1'b0;
    qw(); scl = 1'b1;
    qw(); nack = sdaBus;
    qw(); scl = 1'b0;
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      qw(); mLow = 1'b0;
      qw(); scl = 1'b1;
      qw(); b[i] = sdaBus;
      qw(); scl = 1'b0;
    end
    qw(); mLow = mAck;
    qw(); scl = 1'b1;
    qw(); qw(); scl = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    bit nk;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    qw();
    // R10 reset state
    check(sdaOe == 1'b0, "R10 sdaOe", sdaOe, 0);
    check(regAddr == 8'h00, "R10 pointer", regAddr, 0);
    check(regWe == 1'b0, "R10 regWe", regWe, 0);

    // R3 every foreign address is refused
    for (int a = 0; a < 128; a++) begin
      if (7'(a) != DEV) begin
        busStart();
        sendByte({7'(a), 1'b0}, nk);
        check(nk == 1'b1, "R3 foreign addr nack", nk, 1);
        busStop();
      end
    end
    busStart();
    sendByte({7'h42, 1'b0}, nk);
    sendByte(8'h05, nk);
    check(nk == 1'b1, "R3 bytes after foreign addr", nk, 1);
    sendByte(8'h77, nk);
    check(nk == 1'b1, "R3 data after foreign addr", nk, 1);
    busStop();
    check(weCount == 0, "R3 no writes", weCount, 0);
    check(regAddr == 8'h00, "R3 pointer untouched", regAddr, 0);

    // byte write
    busStart();
    sendByte({DEV, 1'b0}, nk);
    check(nk == 1'b0, "R2 address ack", nk, 0);
    sendByte(8'h10, nk);
    check(nk == 1'b0, "R4 sub-address ack", nk, 0);
    check(regAddr == 8'h10, "R4 pointer loaded", regAddr, 8'h10);
    sendByte(8'hA5, nk);
    check(nk == 1'b0, "R5 data ack", nk, 0);
    busStop();
    check(sdaOe == 1'b0, "R1 released after stop", sdaOe, 0);
    check(mem[8'h10] == 8'hA5, "R5 byte written", mem[8'h10], 8'hA5);
    check(regAddr == 8'h11, "R5 pointer advanced", regAddr, 8'h11);

    // multibyte write at 0x20
    busStart();
    sendByte({DEV, 1'b0}, nk);
    sendByte(8'h20, nk);
    sendByte(8'h11, nk);
    sendByte(8'h22, nk);
    sendByte(8'h33, nk);
    check(nk == 1'b0, "R5 multibyte ack", nk, 0);
    busStop();
    check(regAddr == 8'h23, "R5 pointer after multibyte", regAddr, 8'h23);

    // random read over repeated START
    busStart();
    sendByte({DEV, 1'b0}, nk);
    sendByte(8'h20, nk);
    busStart();
    sendByte({DEV, 1'b1}, nk);
    check(nk == 1'b0, "R8 read address ack", nk, 0);
    recvByte(1'b1, b);
    check(b == 8'h11, "R8 first byte", b, 8'h11);
    recvByte(1'b1, b);
    check(b == 8'h22, "R7 second byte", b, 8'h22);
    recvByte(1'b0, b);
    check(b == 8'h33, "R7 third byte", b, 8'h33);
    check(sdaOe == 1'b0, "R7 released after nack", sdaOe, 0);
    busStop();
    check(regAddr == 8'h23, "R7 pointer after read", regAddr, 8'h23);

    // current-address read with pointer left by a write
    busStart();
    sendByte({DEV, 1'b0}, nk);
    sendByte(8'h21, nk);
    busStop();
    busStart();
    sendByte({DEV, 1'b1}, nk);
    check(nk == 1'b0, "R6 read address ack", nk, 0);
    recvByte(1'b0, b);
    busStop();
    check(b == 8'h22, "R6 current address byte", b, 8'h22);
    check(regAddr == 8'h22, "R6 pointer after read", regAddr, 8'h22);

    // full sweep write, pointer wraps
    busStart();
    sendByte({DEV, 1'b0}, nk);
    sendByte(8'h00, nk);
    for (int i = 0; i < 256; i++) begin
      sendByte(pat(i), nk);
      check(nk == 1'b0, "R5 sweep write ack", nk, 0);
    end
    busStop();
    check(regAddr == 8'h00, "R5 pointer wrap", regAddr, 0);
    check(weCount == 260, "R5 write strobe count", weCount, 260);

    // full sweep sequential read, MSB first
    busStart();
    sendByte({DEV, 1'b0}, nk);
    sendByte(8'h00, nk);
    busStart();
    sendByte({DEV, 1'b1}, nk);
    for (int i = 0; i < 256; i++) begin
      recvByte(i != 255, b);
      check(b == pat(i), "R9 sweep read data", b, pat(i));
    end
    busStop();
    check(regAddr == 8'h00, "R7 pointer after sweep read", regAddr, 0);
    check(sdaOe == 1'b0, "R1 idle at end", sdaOe, 0);

    done = 1;
    summary();
  end
endmodule